// File: doc/BRIEF.md
# Serial Channel Card Controller

This block is the card-side logic of a relay and digital I/O card that a host controls over a few serial lines. The host shifts a 16-bit output frame in on a data line, one bit per rising edge of an output clock. A strobe then moves the frame into the output channel latches. The same strobe captures ten parallel input channels into a 16-bit input frame, which the host then clocks out on a separate return line.

Host-side lines arrive asynchronously. The output clock, the input clock, the strobe and the output data each pass through two flip-flops before the block acts on them. A rising edge of a host line therefore takes effect at the third rising edge of `clk`.

An active-low driver enable keeps every relay and output open from processor reset until the first strobe, and keeps them enabled after that until the next reset. Every strobe also starts a coil-boost window of `BOOST_CYCLES` system clocks, so that relays can pull in quickly.

Top module: `chancard_ctrl`

## Requirements
- R1: While `rst_n` is low, `drv_en_n` is 1 and `out_ch`, `coil_boost` and `host_idat` are all 0.
- R2: On a strobe, `out_ch` takes the last 16 bits shifted in on `host_odat`, most significant bit first. The first of those 16 bits lands in bit 15 and the last in bit 0.
- R3: `out_ch` does not change while bits are being shifted in, and changes only on a strobe.
- R4: A strobe captures the input frame `{6'b0, in_ch[9:0]}`. The return line `host_idat` then shows bit 15 of the frame. Each rising edge of `host_iclk` advances one bit toward bit 0, and zeros follow after bit 0.
- R5: The six upper positions of the input frame (bits 15..10) always read as zero.
- R6: After reset `drv_en_n` stays 1 until the first strobe. It then goes to 0 and stays 0 through later strobes until reset.
- R7: Each strobe holds `coil_boost` high for exactly `BOOST_CYCLES` clock cycles.
- R8: A strobe that arrives while the boost window is active restarts the window at its full length.
- R9: A rising edge of a host line takes effect at the third rising edge of `clk` after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Processor reset, active low, asynchronous |
| host_oclk | input | 1 | Output shift clock from the host |
| host_odat | input | 1 | Output serial data from the host |
| host_iclk | input | 1 | Input shift clock from the host |
| host_strobe | input | 1 | Latch, capture and enable strobe |
| in_ch | input | 10 | Parallel input channels |
| host_idat | output | 1 | Input serial data to the host |
| out_ch | output | 16 | Latched output channel values |
| drv_en_n | output | 1 | Active-low driver enable |
| coil_boost | output | 1 | Relay coil boost window flag |

## Verification
A host line raised just after a falling edge acts at the third rising edge. The bench confirms that `out_ch` still holds its old value after the first and second edges and has the new value after the third. Every other stimulus holds each host line high for four cycles and low for four more before any output is sampled, so all results are settled when they are read. The serial return bits are queued as expected items when a frame is captured. Each queued bit is compared at the falling edge after its input clock pulse has finished. The boost length is taken by counting the falling edges on which `coil_boost` is high over a window longer than any expected burst. For a restarted window, the expected count is the gap between the two strobes plus `BOOST_CYCLES`.

// File: rtl/chancard_ctrl.sv
`timescale 1ns/1ps
module chancard_ctrl #(
  parameter int IN_CH        = 10,
  parameter int BYTE_W       = 8,
  parameter int BOOST_CYCLES = 5_000_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_oclk,
  input  logic                host_odat,
  input  logic                host_iclk,
  input  logic                host_strobe,
  input  logic [IN_CH-1:0]    in_ch,
  output logic                host_idat,
  output logic [2*BYTE_W-1:0] out_ch,
  output logic                drv_en_n,
  output logic                coil_boost
);
  localparam int FRAME_W = 2 * BYTE_W;
  localparam int LEAD_W  = IN_CH - BYTE_W;
  localparam int CNT_W   = $clog2(BOOST_CYCLES + 1);

  logic [2:0] oc_s, ic_s, st_s;
  logic [1:0] od_s;
  logic [BYTE_W-1:0] o_hi, o_lo, i_lead, i_tail;
  logic [CNT_W-1:0] boost_cnt;

  wire oc_rise = oc_s[1] & ~oc_s[2];
  wire ic_rise = ic_s[1] & ~ic_s[2];
  wire st_rise = st_s[1] & ~st_s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_s <= '0;
      ic_s <= '0;
      st_s <= '0;
      od_s <= '0;
    end else begin
      oc_s <= {oc_s[1:0], host_oclk};
      ic_s <= {ic_s[1:0], host_iclk};
      st_s <= {st_s[1:0], host_strobe};
      od_s <= {od_s[0], host_odat};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_hi   <= '0;
      o_lo   <= '0;
      out_ch <= '0;
    end else begin
      if (oc_rise) begin
        o_hi <= {o_hi[BYTE_W-2:0], o_lo[BYTE_W-1]};
        o_lo <= {o_lo[BYTE_W-2:0], od_s[1]};
      end
      if (st_rise) out_ch <= {o_hi, o_lo};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_lead <= '0;
      i_tail <= '0;
    end else if (st_rise) begin
      i_lead <= BYTE_W'(in_ch[IN_CH-1 -: LEAD_W]);
      i_tail <= in_ch[BYTE_W-1:0];
    end else if (ic_rise) begin
      i_lead <= {i_lead[BYTE_W-2:0], i_tail[BYTE_W-1]};
      i_tail <= {i_tail[BYTE_W-2:0], 1'b0};
    end
  end

  assign host_idat = i_lead[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       drv_en_n <= 1'b1;
    else if (st_rise) drv_en_n <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              boost_cnt <= '0;
    else if (st_rise)        boost_cnt <= CNT_W'(BOOST_CYCLES);
    else if (boost_cnt != 0) boost_cnt <= boost_cnt - 1'b1;
  end

  assign coil_boost = (boost_cnt != 0);

  if (FRAME_W != 16) begin : g_frame_w_unused
  end
endmodule

module chancard_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        drv_en_n,
  input logic        coil_boost,
  input logic [15:0] out_ch
);
  // R6
  en_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en_n |=> !drv_en_n);
  // R6
  en_opens_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drv_en_n) |-> coil_boost);
  // R7
  boost_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coil_boost) |-> !drv_en_n);
  // R3
  latch_moves_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_ch) |-> (coil_boost && !drv_en_n));
endmodule

bind chancard_ctrl chancard_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .drv_en_n(drv_en_n),
  .coil_boost(coil_boost), .out_ch(out_ch)
);

// File: tb/chancard_ctrl_tb_top.sv
`timescale 1ns/1ps
module chancard_ctrl_tb_top;
  localparam int BOOST = 20;

  logic clk = 0, rst_n = 0;
  logic oclk = 0, odat = 0, iclk = 0, strobe = 0;
  logic [9:0] in_ch = '0;
  logic idat, en_n, boost;
  logic [15:0] out_ch;

  int total = 0, bad = 0;
  bit done = 0;
  bit exp_q[$];
  string tag_q[$];
  event sample_ev;

  always #5 clk = ~clk;

  chancard_ctrl #(.BOOST_CYCLES(BOOST)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_oclk(oclk), .host_odat(odat),
    .host_iclk(iclk), .host_strobe(strobe), .in_ch(in_ch),
    .host_idat(idat), .out_ch(out_ch), .drv_en_n(en_n), .coil_boost(boost)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    odat = b; cyc(1);
    oclk = 1; cyc(4);
    oclk = 0; cyc(4);
  endtask

  task automatic shift_word(logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic strobe_count(int gap, output int cnt);
    cnt = 0;
    strobe = 1;
    for (int k = 1; k <= 70; k++) begin
      @(negedge clk);
      if (boost) cnt++;
      if (k == 4) strobe = 0;
      if (gap > 0 && k == gap) strobe = 1;
      if (gap > 0 && k == gap + 4) strobe = 0;
    end
  endtask

  task automatic read_frame(logic [9:0] d);
    logic [15:0] f = {6'b0, d};
    for (int i = 15; i >= 0; i--) begin
      exp_q.push_back(f[i]);
      tag_q.push_back(i >= 10 ? "R5" : "R4");
    end
    exp_q.push_back(1'b0);
    tag_q.push_back("R4");
    ->sample_ev;
    cyc(1);
    for (int i = 0; i < 16; i++) begin
      iclk = 1; cyc(4);
      iclk = 0; cyc(4);
      ->sample_ev;
      cyc(1);
    end
  endtask

  initial begin
    forever begin
      @(sample_ev);
      if (exp_q.size() == 0) chk("R4 queue underrun", 1, 0);
      else chk(tag_q.pop_front(), idat, exp_q.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int n;
    cyc(3);
    chk("R1 en", en_n, 1);
    chk("R1 out", out_ch, 0);
    chk("R1 boost", boost, 0);
    chk("R1 idat", idat, 0);
    rst_n = 1;
    cyc(2);

    shift_word(16'hA5C3);
    chk("R3 no strobe", out_ch, 0);
    chk("R6 before strobe", en_n, 1);

    in_ch = 10'h2B7;
    strobe_count(0, n);
    chk("R7 window", n, BOOST);
    chk("R2 latch", out_ch, 16'hA5C3);
    chk("R6 enabled", en_n, 0);
    read_frame(10'h2B7);

    for (int i = 15; i >= 8; i--) send_bit(i[0] ? 1'b0 : 1'b1);
    chk("R3 mid shift", out_ch, 16'hA5C3);
    shift_word(16'h3C96);
    chk("R3 after shift", out_ch, 16'hA5C3);

    in_ch = 10'h3FF;
    strobe_count(8, n);
    chk("R8 restart", n, BOOST + 8);
    chk("R2 second latch", out_ch, 16'h3C96);
    chk("R6 stays enabled", en_n, 0);
    read_frame(10'h3FF);

    shift_word(16'h0001);
    strobe = 1;
    cyc(1); chk("R9 edge1", out_ch, 16'h3C96);
    cyc(1); chk("R9 edge2", out_ch, 16'h3C96);
    cyc(1); chk("R9 edge3", out_ch, 16'h0001);
    strobe = 0;
    cyc(40);
    chk("R7 ended", boost, 0);

    rst_n = 0;
    cyc(1);
    chk("R1 reset en", en_n, 1);
    chk("R1 reset out", out_ch, 0);
    chk("R1 reset boost", boost, 0);
    rst_n = 1;
    cyc(5);
    chk("R6 rearmed", en_n, 1);

    chk("R4 queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule